// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This controller steps through a multi-register block move, either a load or a store. It accepts a 16-bit register list, a base address and a set of mode flags: ascending or descending, pre- or post-index, load or store, base update, and user-bank access. The caller pulses `start` while the block is idle. The block then issues one word access for each selected register on a valid/ready request port. Every access carries the address, the register index, the direction and a sequential-access hint. It keeps the request stable until the memory side accepts it.

The block always places the transfer window at its lowest address, whatever the addressing mode. It then walks the list from the lowest register index upward. The updated base value and a write strobe are reported at a point that depends on the kind of transfer. For a load, the strobe comes before any data moves. For a store, it comes after the last access. When the operation finishes, the block raises a one-cycle `done`. With `done` it can also request that the saved status be copied into the current status, or flag that the following fetch must be nonsequential. The register file and the memory are outside this block.

Top module: `blkXferSeq`

## Requirements
- R1: A start with an all-zero list makes no request. `done` rises in the cycle after `start` is sampled, with `baseWbValid`, `statusRestore` and `nextFetchNonSeq` all low.
- R2: Let `count` be the number of set list bits. The first request address is chosen as follows:
  - `ascend`=1, `preIndex`=0: `baseAddr`.
  - `ascend`=1, `preIndex`=1: `baseAddr`+4.
  - `ascend`=0, `preIndex`=1: `baseAddr`-4·count.
  - `ascend`=0, `preIndex`=0: `baseAddr`-4·count+4.
- R3: Requests name the selected registers in strictly increasing index order on `reqReg`. Each accepted request advances `reqAddr` by 4 for the next request.
- R4: `reqSeq` is 0 on the first request of an operation and 1 on every later request.
- R5: While `reqValid` is high and `reqReady` is low, `reqAddr`, `reqReg` and `reqWrite` hold their values into the next cycle.
- R6: When `writeBack` is set and the list is non-empty, `baseWbValid` pulses exactly once per operation. At that pulse, `baseWbValue` equals `baseAddr`+4·count when ascending and `baseAddr`-4·count when descending. When `writeBack` is clear, the pulse never occurs.
- R7: For a load, the base-update pulse falls in the first request cycle, which comes before any request is accepted. For a store, it falls in the `done` cycle.
- R8: `userBankAccess` is high during request cycles exactly when `userBank` is set and either the operation is a store or bit 15 of the list is clear. It is low whenever `reqValid` is low.
- R9: `statusRestore` is high only in the `done` cycle of a load whose list has bit 15 set, with `userBank` set and `modeIsUserOrSys` low.
- R10: After the last accepted request, a load spends one cycle with `busy` high and no request, and then raises `done`. A store raises `done` in the cycle right after the last acceptance, together with `nextFetchNonSeq`.
- R11: `reqWrite` is 1 for a store (`isLoad`=0) and 0 for a load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| start | input | 1 | Begin an operation; sampled only while idle |
| regList | input | 16 | Register selection, bit i selects register i |
| baseAddr | input | 32 | Base address value |
| ascend | input | 1 | 1 = addresses grow from the base, 0 = shrink |
| preIndex | input | 1 | 1 = step before the access, 0 = after |
| isLoad | input | 1 | 1 = load from memory, 0 = store |
| writeBack | input | 1 | Report an updated base |
| userBank | input | 1 | User-bank / status-restore qualifier |
| modeIsUserOrSys | input | 1 | Current mode has no saved status |
| reqReady | input | 1 | Memory accepts the current request |
| reqValid | output | 1 | A request is presented |
| reqAddr | output | 32 | Word address of the request |
| reqReg | output | 4 | Register index for the request |
| reqWrite | output | 1 | 1 = write to memory |
| reqSeq | output | 1 | 1 = sequential to previous access |
| userBankAccess | output | 1 | Access targets the user register bank |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| baseWbValid | output | 1 | Base update strobe |
| baseWbValue | output | 32 | Updated base value |
| statusRestore | output | 1 | Copy saved status into current status |
| nextFetchNonSeq | output | 1 | Next instruction fetch is nonsequential |

## Verification
The hardest case to reach from the ports is a status-restore load. It needs bit 15 in the list, the user-bank flag and a privileged mode all at once. Random lists set bit 15 only half the time, and the other two flags then cut the chance further. Directed runs therefore force bit 15 with both mode values, and the random mix also stalls `reqReady` for 0 to 2 cycles on every request. These stalls exercise the hold behaviour and the one-shot base-update pulse for loads under back-pressure.

// File: rtl/blkXferPkg.sv
package blkXferPkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACCESS = 2'd1,
    ST_TAIL   = 2'd2,
    ST_FINISH = 2'd3
  } seqState_t;

  typedef struct packed {
    logic load;      // capture operands at start
    logic advance;   // current request accepted
    logic accessOn;  // request cycle
    logic firstCyc;  // first request cycle of an operation
    logic finishOn;  // completion cycle
  } ctrlStrobes_t;
endpackage

// File: rtl/blkXferPath.sv
module blkXferPath
  import blkXferPkg::*;
#(
  parameter int LIST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W),
  localparam int CNT_W     = $clog2(LIST_W + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      stb,
  input  logic [LIST_W-1:0] regList,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              ascend,
  input  logic              preIndex,
  input  logic              isLoad,
  input  logic              writeBack,
  input  logic              userBank,
  input  logic              modeIsUserOrSys,
  output logic              listEmptyIn,
  output logic              lastBeat,
  output logic              ldHeld,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [IDX_W-1:0]  reqReg,
  output logic              reqSeq,
  output logic              reqWrite,
  output logic              baseWbValid,
  output logic [ADDR_W-1:0] baseWbValue,
  output logic              userBankAccess,
  output logic              statusRestore,
  output logic              nextFetchNonSeq
);
  localparam logic [ADDR_W-1:0] BEAT = ADDR_W'(BEAT_BYTES);

  logic [LIST_W-1:0] maskQ;
  logic [ADDR_W-1:0] addrQ, newBaseQ;
  logic              seqQ, ldQ, wbQ, userQ, restoreQ, nonEmptyQ;

  logic [CNT_W-1:0]  setCount;
  logic [ADDR_W-1:0] spanBytes, startAddr, newBase;
  logic              topSel;

  function automatic logic [IDX_W-1:0] lowIdx(input logic [LIST_W-1:0] m);
    lowIdx = '0;
    for (int i = LIST_W - 1; i >= 0; i--)
      if (m[i]) lowIdx = IDX_W'(i);
  endfunction

  always_comb begin
    setCount = '0;
    for (int i = 0; i < LIST_W; i++)
      setCount = setCount + CNT_W'(regList[i]);
  end

  assign spanBytes = ADDR_W'(setCount) * BEAT;
  assign topSel    = regList[LIST_W-1];

  always_comb begin
    unique case ({ascend, preIndex})
      2'b10:   startAddr = baseAddr;
      2'b11:   startAddr = baseAddr + BEAT;
      2'b01:   startAddr = baseAddr - spanBytes;
      default: startAddr = baseAddr - spanBytes + BEAT;
    endcase
    newBase = ascend ? baseAddr + spanBytes : baseAddr - spanBytes;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskQ     <= '0;
      addrQ     <= '0;
      newBaseQ  <= '0;
      seqQ      <= 1'b0;
      ldQ       <= 1'b0;
      wbQ       <= 1'b0;
      userQ     <= 1'b0;
      restoreQ  <= 1'b0;
      nonEmptyQ <= 1'b0;
    end else if (stb.load) begin
      maskQ     <= regList;
      addrQ     <= startAddr;
      newBaseQ  <= newBase;
      seqQ      <= 1'b0;
      ldQ       <= isLoad;
      wbQ       <= writeBack;
      userQ     <= userBank & (~isLoad | ~topSel);
      restoreQ  <= isLoad & userBank & topSel & ~modeIsUserOrSys;
      nonEmptyQ <= |regList;
    end else if (stb.advance) begin
      maskQ <= maskQ & (maskQ - 1'b1);
      addrQ <= addrQ + BEAT;
      seqQ  <= 1'b1;
    end
  end

  assign listEmptyIn     = ~|regList;
  assign lastBeat        = ~|(maskQ & (maskQ - 1'b1));
  assign ldHeld          = ldQ;
  assign reqAddr         = addrQ;
  assign reqReg          = lowIdx(maskQ);
  assign reqSeq          = seqQ;
  assign reqWrite        = ~ldQ;
  assign baseWbValue     = newBaseQ;
  assign baseWbValid     = wbQ & nonEmptyQ &
                           ((ldQ & stb.firstCyc) | (~ldQ & stb.finishOn));
  assign userBankAccess  = stb.accessOn & userQ;
  assign statusRestore   = stb.finishOn & restoreQ & nonEmptyQ;
  assign nextFetchNonSeq = stb.finishOn & ~ldQ & nonEmptyQ;
endmodule

// File: rtl/blkXferCtrl.sv
module blkXferCtrl
  import blkXferPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         reqReady,
  input  logic         listEmptyIn,
  input  logic         lastBeat,
  input  logic         ldHeld,
  output ctrlStrobes_t stb,
  output logic         reqValid,
  output logic         busy,
  output logic         done
);
  seqState_t stateQ, stateD;
  logic      firstQ;

  always_comb begin
    stateD       = stateQ;
    stb          = '0;
    stb.accessOn = (stateQ == ST_ACCESS);
    stb.finishOn = (stateQ == ST_FINISH);
    stb.firstCyc = firstQ & (stateQ == ST_ACCESS);
    unique case (stateQ)
      ST_IDLE: if (start) begin
        stb.load = 1'b1;
        stateD   = listEmptyIn ? ST_FINISH : ST_ACCESS;
      end
      ST_ACCESS: if (reqReady) begin
        stb.advance = 1'b1;
        if (lastBeat) stateD = ldHeld ? ST_TAIL : ST_FINISH;
      end
      ST_TAIL:   stateD = ST_FINISH;
      default:   stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      firstQ <= 1'b0;
    end else begin
      stateQ <= stateD;
      firstQ <= stb.load & ~listEmptyIn;
    end
  end

  assign reqValid = (stateQ == ST_ACCESS);
  assign busy     = (stateQ != ST_IDLE);
  assign done     = (stateQ == ST_FINISH);
endmodule

// File: rtl/blkXferSeq.sv
module blkXferSeq
  import blkXferPkg::*;
#(
  parameter int LIST_W     = 16,
  parameter int ADDR_W     = 32,
  parameter int BEAT_BYTES = 4,
  localparam int IDX_W     = $clog2(LIST_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LIST_W-1:0] regList,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic              ascend,
  input  logic              preIndex,
  input  logic              isLoad,
  input  logic              writeBack,
  input  logic              userBank,
  input  logic              modeIsUserOrSys,
  input  logic              reqReady,
  output logic              reqValid,
  output logic [ADDR_W-1:0] reqAddr,
  output logic [IDX_W-1:0]  reqReg,
  output logic              reqWrite,
  output logic              reqSeq,
  output logic              userBankAccess,
  output logic              busy,
  output logic              done,
  output logic              baseWbValid,
  output logic [ADDR_W-1:0] baseWbValue,
  output logic              statusRestore,
  output logic              nextFetchNonSeq
);
  ctrlStrobes_t stb;
  logic listEmptyIn, lastBeat, ldHeld;

  blkXferCtrl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .reqReady(reqReady),
    .listEmptyIn(listEmptyIn), .lastBeat(lastBeat), .ldHeld(ldHeld),
    .stb(stb), .reqValid(reqValid), .busy(busy), .done(done)
  );

  blkXferPath #(.LIST_W(LIST_W), .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)) u_path (
    .clk(clk), .rstN(rstN), .stb(stb), .regList(regList), .baseAddr(baseAddr),
    .ascend(ascend), .preIndex(preIndex), .isLoad(isLoad), .writeBack(writeBack),
    .userBank(userBank), .modeIsUserOrSys(modeIsUserOrSys),
    .listEmptyIn(listEmptyIn), .lastBeat(lastBeat), .ldHeld(ldHeld),
    .reqAddr(reqAddr), .reqReg(reqReg), .reqSeq(reqSeq), .reqWrite(reqWrite),
    .baseWbValid(baseWbValid), .baseWbValue(baseWbValue),
    .userBankAccess(userBankAccess), .statusRestore(statusRestore),
    .nextFetchNonSeq(nextFetchNonSeq)
  );
endmodule

// File: rtl/blkXferSeqChk.sv
module blkXferSeqChk #(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [IDX_W-1:0]  reqReg,
  input logic              reqWrite,
  input logic              reqSeq,
  input logic              userBankAccess,
  input logic              done,
  input logic              statusRestore,
  input logic              nextFetchNonSeq
);
  AST_HOLD_STALL: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && !reqReady |=> reqValid && $stable(reqAddr) && $stable(reqReg) && $stable(reqWrite)); // R5
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) ##1 reqValid |-> reqAddr == $past(reqAddr) + ADDR_W'(4)); // R3
  AST_REG_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) ##1 reqValid |-> reqReg > $past(reqReg)); // R3
  AST_SEQ_LATER: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) ##1 reqValid |-> reqSeq); // R4
  AST_USER_IN_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    userBankAccess |-> reqValid); // R8
  AST_RESTORE_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    statusRestore |-> done && !reqWrite); // R9
  AST_NONSEQ_AT_DONE: assert property (@(posedge clk) disable iff (!rstN)
    nextFetchNonSeq |-> done && !reqValid); // R10
endmodule

bind blkXferSeq blkXferSeqChk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .reqAddr(reqAddr), .reqReg(reqReg), .reqWrite(reqWrite), .reqSeq(reqSeq),
  .userBankAccess(userBankAccess), .done(done), .statusRestore(statusRestore),
  .nextFetchNonSeq(nextFetchNonSeq)
);

// File: tb/blkXferSeq_tb.sv
module blkXferSeq_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [15:0] regList = '0;
  logic [31:0] baseAddr = '0;
  logic        ascend = 1'b0, preIndex = 1'b0, isLoad = 1'b0, writeBack = 1'b0;
  logic        userBank = 1'b0, modeIsUserOrSys = 1'b0, reqReady = 1'b0;
  logic        reqValid, reqWrite, reqSeq, userBankAccess, busy, done;
  logic        baseWbValid, statusRestore, nextFetchNonSeq;
  logic [31:0] reqAddr, baseWbValue;
  logic [3:0]  reqReg;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  blkXferSeq u_dut (
    .clk(clk), .rstN(rstN), .start(start), .regList(regList), .baseAddr(baseAddr),
    .ascend(ascend), .preIndex(preIndex), .isLoad(isLoad), .writeBack(writeBack),
    .userBank(userBank), .modeIsUserOrSys(modeIsUserOrSys), .reqReady(reqReady),
    .reqValid(reqValid), .reqAddr(reqAddr), .reqReg(reqReg), .reqWrite(reqWrite),
    .reqSeq(reqSeq), .userBankAccess(userBankAccess), .busy(busy), .done(done),
    .baseWbValid(baseWbValid), .baseWbValue(baseWbValue),
    .statusRestore(statusRestore), .nextFetchNonSeq(nextFetchNonSeq)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles == 150000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  function automatic int popc(input logic [15:0] l);
    int c = 0;
    for (int i = 0; i < 16; i++) c += int'(l[i]);
    return c;
  endfunction

  function automatic logic [31:0] expStart(input logic [15:0] l, input logic [31:0] b,
                                           input bit asc, input bit pre);
    logic [31:0] span = 32'(popc(l) * 4);
    if (asc) return pre ? b + 32'd4 : b;
    return pre ? b - span : b - span + 32'd4;
  endfunction

  function automatic logic [31:0] expBase(input logic [15:0] l, input logic [31:0] b, input bit asc);
    logic [31:0] span = 32'(popc(l) * 4);
    return asc ? b + span : b - span;
  endfunction

  task automatic runOp(input logic [15:0] l, input logic [31:0] b, input bit asc, input bit pre,
                       input bit ld, input bit wb, input bit ub, input bit us);
    logic [31:0] addr = expStart(l, b, asc, pre);
    bit first = 1'b1;
    int wbSeen = 0;
    bit expUser = ub && (!ld || !l[15]);
    bit expRest = ld && ub && l[15] && !us;
    regList = l; baseAddr = b; ascend = asc; preIndex = pre; isLoad = ld;
    writeBack = wb; userBank = ub; modeIsUserOrSys = us; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    regList = 16'($urandom); baseAddr = $urandom;
    for (int i = 0; i < 16; i++) begin
      if (!l[i]) continue;
      begin
        int stalls = $urandom_range(0, 2);
        for (int s = 0; s <= stalls; s++) begin
          chk(reqValid === 1'b1, "R3 reqValid", reqValid, 1);
          chk(reqReg === 4'(i), "R3 reqReg order", reqReg, i);
          chk(reqAddr === addr, s == 0 ? "R2/R3 reqAddr" : "R5 held reqAddr", reqAddr, addr);
          chk(reqSeq === !first, "R4 reqSeq", reqSeq, !first);
          chk(reqWrite === !ld, "R11 reqWrite", reqWrite, !ld);
          chk(userBankAccess === expUser, "R8 userBankAccess", userBankAccess, expUser);
          chk(baseWbValid === (ld && wb && first && s == 0), "R7 load base strobe",
              baseWbValid, ld && wb && first && s == 0);
          if (baseWbValid === 1'b1) begin
            wbSeen++;
            chk(baseWbValue === expBase(l, b, asc), "R6 base value", baseWbValue, expBase(l, b, asc));
          end
          chk(done === 1'b0, "R10 no early done", done, 0);
          reqReady = (s == stalls);
          @(negedge clk);
          reqReady = 1'b0;
        end
        addr += 32'd4;
        first = 1'b0;
      end
    end
    if (ld && l != 0) begin
      chk(busy === 1'b1 && reqValid === 1'b0 && done === 1'b0, "R10 load idle cycle",
          {busy, reqValid, done}, 3'b100);
      @(negedge clk);
    end
    chk(done === 1'b1, l == 0 ? "R1 empty done" : "R10 done", done, 1);
    chk(reqValid === 1'b0, "R1 no request at done", reqValid, 0);
    chk(nextFetchNonSeq === (!ld && l != 0), "R10 nextFetchNonSeq", nextFetchNonSeq, !ld && l != 0);
    chk(statusRestore === expRest, "R9 statusRestore", statusRestore, expRest);
    chk(baseWbValid === (!ld && wb && l != 0), "R7 store base strobe", baseWbValid, !ld && wb && l != 0);
    if (baseWbValid === 1'b1) begin
      wbSeen++;
      chk(baseWbValue === expBase(l, b, asc), "R6 base value", baseWbValue, expBase(l, b, asc));
    end
    chk(wbSeen == ((wb && l != 0) ? 1 : 0), "R6 strobe count", wbSeen, (wb && l != 0) ? 1 : 0);
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 back to idle", {busy, done}, 0);
  endtask

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && reqValid === 1'b0 && done === 1'b0, "R1 reset state",
        {busy, reqValid, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && baseWbValid === 1'b0, "R1 idle after reset", {busy, baseWbValid}, 0);
    // R1 empty list, both directions
    runOp(16'h0000, 32'h1000, 1, 0, 1, 1, 1, 0);
    runOp(16'h0000, 32'h1000, 0, 1, 0, 1, 0, 0);
    // R2 all four modes
    runOp(16'h00F1, 32'h2000, 1, 0, 1, 1, 0, 0);
    runOp(16'h00F1, 32'h2000, 1, 1, 0, 1, 0, 0);
    runOp(16'h00F1, 32'h2000, 0, 1, 1, 1, 0, 0);
    runOp(16'h00F1, 32'h2000, 0, 0, 0, 1, 0, 0);
    // R9 restore with bit 15, both mode values; R8 store with user bank
    runOp(16'h8003, 32'h3000, 1, 0, 1, 0, 1, 0);
    runOp(16'h8003, 32'h3000, 1, 0, 1, 0, 1, 1);
    runOp(16'h8003, 32'h3000, 0, 0, 0, 1, 1, 0);
    runOp(16'hFFFF, 32'h0000_0010, 0, 1, 1, 1, 1, 0);
    runOp(16'h8000, 32'hFFFF_FFFC, 1, 1, 0, 1, 0, 0);
    for (int n = 0; n < 300; n++)
      runOp(16'($urandom), {$urandom, 2'b00} >> 2 << 2, 1'($urandom), 1'($urandom),
            1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule